// File: doc/BRIEF.md
# One-Way Delay Measurement Initiator

This block runs the starting side of a message type 5 one-way delay measurement. Software writes a control word holding a measurement identifier, a remote-request bit, a two-step bit and a start bit. The block then emits the opening frame of the exchange. Each frame is a 20-byte parallel payload, presented for one cycle together with a destination MAC address and a VLAN setting that were captured from configuration when the measurement started. In two-step mode a follow-up frame comes next. It carries the transmit time T1, which is sampled from the time-of-day input in the cycle the request leaves.

After its last frame the block waits a programmable number of cycles for a response. A response is accepted only if it carries the programmed identifier. The block takes the receive time T2 and the far-end compensation CV2 from the response. The near-end compensation CV1 is supplied by the downstream timestamping logic. The block computes the delay as (T2 − CV2) − (T1 + CV1) in seconds and nanoseconds. It reports the result with a done flag, or raises a timeout flag when no response arrives. The MAC, the PHY and the insertion of correction values into frames are handled outside the block.

Top module: `owd_initiator`

## Requirements
- R1: After reset, tx_valid, done and timeout_err are low. A measurement starts only on a cycle with ctl_wr and ctl_start both high. A control write with ctl_start low sends no frame.
- R2: The first frame is presented in the cycle after the start write. Its action byte is 0x00 when ctl_remote=0 and ctl_two_step=0, 0x01 when ctl_remote=0 and ctl_two_step=1, 0x03 when ctl_remote=1 and ctl_two_step=0, and 0x04 when ctl_remote=1 and ctl_two_step=1.
- R3: Payload layout, most significant byte first: bits 159:152 hold the measurement ID, bits 151:144 the action type, bits 143:64 an 80-bit timestamp (143:96 seconds, 95:64 nanoseconds) and bits 63:0 a compensation value. The compensation value is in nanoseconds times 2^16, so bits 47:16 are whole nanoseconds. The bits of tx_payload are all zero when no frame is presented.
- R4: In two-step mode, the request frame carries a zero timestamp and a zero compensation. In the next cycle a follow-up frame with action 0x05 is sent, and its timestamp field equals the tod value of the request cycle.
- R5: In one-step mode, the request frame's timestamp field equals tod in that same cycle and its compensation field is zero. No follow-up is sent.
- R6: During every frame, tx_dst_mac, tx_vlan_en and tx_vlan_tag equal the cfg_dst_mac, cfg_vlan_en and cfg_vlan_tag values present at the start write.
- R7: While waiting, a cycle with rx_valid high is accepted as the response only if byte 0 equals the programmed ID and byte 1 equals 0x02. Any other received payload is ignored.
- R8: On acceptance, delay becomes (T2 − CV2) − (T1 + CV1), with seconds in bits 79:32 and nanoseconds in bits 31:0. Only the whole-nanosecond bits of CV1 (cv1_in, sampled at acceptance) and of CV2 are used. The subtraction borrows when the nanoseconds underflow and the addition carries when they pass 10^9. done rises with the result and stays high until the next accepted start.
- R9: cfg_timeout is captured at start. A response is accepted in the cycles 1 through cfg_timeout+1 after the last frame. If none arrives, timeout_err is set in the cycle after that window and the block returns to idle. timeout_err stays high until the next accepted start. Responses that arrive later are ignored.
- R10: A start write while a measurement is active is ignored. The measurement in progress keeps its ID and settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_meas_id | input | 8 | Measurement identifier |
| ctl_remote | input | 1 | Remote-request select |
| ctl_two_step | input | 1 | Two-step mode select |
| ctl_start | input | 1 | Start bit of the control word |
| cfg_timeout | input | TO_W | Response wait limit in cycles |
| cfg_dst_mac | input | 48 | Destination MAC for the exchange |
| cfg_vlan_en | input | 1 | Insert VLAN tag |
| cfg_vlan_tag | input | 16 | VLAN tag value |
| tod | input | 80 | Time of day, 48-bit seconds and 32-bit nanoseconds |
| cv1_in | input | 64 | Near-end compensation applied downstream |
| rx_valid | input | 1 | Received type 5 payload present |
| rx_payload | input | 160 | Received payload |
| tx_valid | output | 1 | Frame presented this cycle |
| tx_payload | output | 160 | Outgoing payload |
| tx_dst_mac | output | 48 | Frame destination MAC |
| tx_vlan_en | output | 1 | Frame carries a VLAN tag |
| tx_vlan_tag | output | 16 | Frame VLAN tag |
| done | output | 1 | Delay result valid |
| timeout_err | output | 1 | No matching response arrived in time |
| delay | output | 80 | Measured one-way delay |

## Verification
The assertions check, on every cycle, the ordering of the frame sequence. A follow-up must directly follow a two-step request and carry the previous cycle's time of day. A one-step request must stand alone. Any request must follow a start write. A rising done must follow a received response, and done and timeout must never both be high. Only the bench's scenarios can show the rest: that the action code is the right one for each mode, the arithmetic of the delay including nanosecond borrow and carry, the filtering of responses with a wrong identifier or action, the exact edge of the timeout window, and that a start write during a measurement is ignored.

// File: rtl/owd_pkg.sv
package owd_pkg;
  localparam int SEC_W = 48;
  localparam int NS_W  = 32;
  localparam int TS_W  = SEC_W + NS_W;
  localparam int CV_W  = 64;
  localparam int ID_W  = 8;
  localparam int AT_W  = 8;
  localparam int PL_W  = ID_W + AT_W + TS_W + CV_W;
  localparam int CV_FRAC = 16;

  localparam logic [AT_W-1:0] AT_REQ     = 8'h00;
  localparam logic [AT_W-1:0] AT_REQ_FU  = 8'h01;
  localparam logic [AT_W-1:0] AT_RESP    = 8'h02;
  localparam logic [AT_W-1:0] AT_RREQ    = 8'h03;
  localparam logic [AT_W-1:0] AT_RREQ_FU = 8'h04;
  localparam logic [AT_W-1:0] AT_FU      = 8'h05;

  localparam logic [NS_W:0] NS_PER_SEC = 33'd1000000000;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_FU, ST_WAIT} owd_state_e;

  typedef struct packed {
    logic [SEC_W-1:0] sec;
    logic [NS_W-1:0]  ns;
  } owd_ts_t;

  // a - b, both normalised (ns below one second)
  function automatic owd_ts_t ts_sub(owd_ts_t a, owd_ts_t b);
    owd_ts_t r;
    logic [NS_W:0] t;
    if (a.ns >= b.ns) begin
      r.ns  = a.ns - b.ns;
      r.sec = a.sec - b.sec;
    end else begin
      t     = {1'b0, a.ns} + NS_PER_SEC - {1'b0, b.ns};
      r.ns  = t[NS_W-1:0];
      r.sec = a.sec - b.sec - {{(SEC_W-1){1'b0}}, 1'b1};
    end
    return r;
  endfunction

  // a + ns, ns below one second
  function automatic owd_ts_t ts_add_ns(owd_ts_t a, logic [NS_W-1:0] ns);
    owd_ts_t r;
    logic [NS_W:0] t;
    t = {1'b0, a.ns} + {1'b0, ns};
    if (t >= NS_PER_SEC) begin
      t     = t - NS_PER_SEC;
      r.sec = a.sec + {{(SEC_W-1){1'b0}}, 1'b1};
    end else begin
      r.sec = a.sec;
    end
    r.ns = t[NS_W-1:0];
    return r;
  endfunction
endpackage

// File: rtl/owd_seq.sv
module owd_seq
  import owd_pkg::*;
#(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            start_req,
  input  logic            two_step,
  input  logic            rx_hit,
  input  logic [TO_W-1:0] timeout,
  output owd_state_e      state,
  output logic            start_acc,
  output logic            resp_acc,
  output logic            expire
);
  owd_state_e      st_q, st_d;
  logic [TO_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    start_acc = 1'b0;
    resp_acc  = 1'b0;
    expire    = 1'b0;
    case (st_q)
      ST_IDLE: if (start_req) begin
        start_acc = 1'b1;
        st_d      = ST_REQ;
      end
      ST_REQ: begin
        if (two_step) begin
          st_d = ST_FU;
        end else begin
          st_d  = ST_WAIT;
          cnt_d = timeout;
        end
      end
      ST_FU: begin
        st_d  = ST_WAIT;
        cnt_d = timeout;
      end
      default: begin
        if (rx_hit) begin
          resp_acc = 1'b1;
          st_d     = ST_IDLE;
        end else if (cnt_q == '0) begin
          expire = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          cnt_d = cnt_q - {{(TO_W-1){1'b0}}, 1'b1};
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign state = st_q;
endmodule

// File: rtl/owd_frame.sv
module owd_frame
  import owd_pkg::*;
(
  input  owd_state_e       state,
  input  logic [ID_W-1:0]  meas_id,
  input  logic [AT_W-1:0]  first_act,
  input  logic [TS_W-1:0]  tod,
  input  logic [TS_W-1:0]  t1,
  output logic             tx_valid,
  output logic [PL_W-1:0]  tx_payload
);
  logic [AT_W-1:0] act;
  logic [TS_W-1:0] ts;
  logic            one_step;

  assign one_step = (first_act == AT_REQ) || (first_act == AT_RREQ);

  always_comb begin
    tx_valid = (state == ST_REQ) || (state == ST_FU);
    act      = (state == ST_FU) ? AT_FU : first_act;
    ts       = '0;
    if (state == ST_REQ && one_step) ts = tod;
    if (state == ST_FU)              ts = t1;
    tx_payload = tx_valid ? {meas_id, act, ts, {CV_W{1'b0}}} : '0;
  end
endmodule

// File: rtl/owd_time_math.sv
module owd_time_math
  import owd_pkg::*;
(
  input  owd_ts_t          t1,
  input  logic [NS_W-1:0]  cv1_ns,
  input  owd_ts_t          t2,
  input  logic [NS_W-1:0]  cv2_ns,
  output owd_ts_t          delay
);
  owd_ts_t rx_side, tx_side;

  always_comb begin
    rx_side = ts_sub(t2, '{sec: '0, ns: cv2_ns});
    tx_side = ts_add_ns(t1, cv1_ns);
    delay   = ts_sub(rx_side, tx_side);
  end
endmodule

// File: rtl/owd_initiator.sv
module owd_initiator
  import owd_pkg::*;
#(
  parameter int TO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [7:0]       ctl_meas_id,
  input  logic             ctl_remote,
  input  logic             ctl_two_step,
  input  logic             ctl_start,
  input  logic [TO_W-1:0]  cfg_timeout,
  input  logic [47:0]      cfg_dst_mac,
  input  logic             cfg_vlan_en,
  input  logic [15:0]      cfg_vlan_tag,
  input  logic [79:0]      tod,
  input  logic [63:0]      cv1_in,
  input  logic             rx_valid,
  input  logic [159:0]     rx_payload,
  output logic             tx_valid,
  output logic [159:0]     tx_payload,
  output logic [47:0]      tx_dst_mac,
  output logic             tx_vlan_en,
  output logic [15:0]      tx_vlan_tag,
  output logic             done,
  output logic             timeout_err,
  output logic [79:0]      delay
);
  localparam int RX_ID_HI = PL_W - 1;
  localparam int RX_AT_HI = PL_W - ID_W - 1;
  localparam int RX_TS_HI = CV_W + TS_W - 1;

  logic [1:0] rst_pipe;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  logic [ID_W-1:0] id_q;
  logic            remote_q, two_q;
  logic [47:0]     mac_q;
  logic            vlan_en_q;
  logic [15:0]     vlan_q;
  logic [TO_W-1:0] to_q;
  logic [TS_W-1:0] t1_q;
  logic            done_q, done_d, err_q, err_d;
  owd_ts_t         delay_q, delay_calc;
  logic [AT_W-1:0] first_act;
  logic            rx_hit, start_acc, resp_acc, expire;
  owd_state_e      state;

  assign rx_hit = rx_valid
               && rx_payload[RX_ID_HI -: ID_W] == id_q
               && rx_payload[RX_AT_HI -: AT_W] == AT_RESP;

  assign first_act = remote_q ? (two_q ? AT_RREQ_FU : AT_RREQ)
                              : (two_q ? AT_REQ_FU  : AT_REQ);

  owd_seq #(.TO_W(TO_W)) u_seq (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .start_req (ctl_wr && ctl_start),
    .two_step  (two_q),
    .rx_hit    (rx_hit),
    .timeout   (to_q),
    .state     (state),
    .start_acc (start_acc),
    .resp_acc  (resp_acc),
    .expire    (expire)
  );

  owd_frame u_frame (
    .state      (state),
    .meas_id    (id_q),
    .first_act  (first_act),
    .tod        (tod),
    .t1         (t1_q),
    .tx_valid   (tx_valid),
    .tx_payload (tx_payload)
  );

  owd_time_math u_math (
    .t1     (owd_ts_t'(t1_q)),
    .cv1_ns (cv1_in[CV_FRAC +: NS_W]),
    .t2     (owd_ts_t'(rx_payload[RX_TS_HI -: TS_W])),
    .cv2_ns (rx_payload[CV_FRAC +: NS_W]),
    .delay  (delay_calc)
  );

  always_comb begin
    done_d = done_q;
    err_d  = err_q;
    if (start_acc) begin
      done_d = 1'b0;
      err_d  = 1'b0;
    end
    if (resp_acc) done_d = 1'b1;
    if (expire)   err_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      id_q      <= '0;
      remote_q  <= 1'b0;
      two_q     <= 1'b0;
      mac_q     <= '0;
      vlan_en_q <= 1'b0;
      vlan_q    <= '0;
      to_q      <= '0;
      t1_q      <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      delay_q   <= '0;
    end else begin
      if (start_acc) begin
        id_q      <= ctl_meas_id;
        remote_q  <= ctl_remote;
        two_q     <= ctl_two_step;
        mac_q     <= cfg_dst_mac;
        vlan_en_q <= cfg_vlan_en;
        vlan_q    <= cfg_vlan_tag;
        to_q      <= cfg_timeout;
      end
      if (state == ST_REQ) t1_q <= tod;
      if (resp_acc)        delay_q <= delay_calc;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign tx_dst_mac  = mac_q;
  assign tx_vlan_en  = vlan_en_q;
  assign tx_vlan_tag = vlan_q;
  assign done        = done_q;
  assign timeout_err = err_q;
  assign delay       = delay_q;
endmodule

// File: rtl/owd_initiator_chk.sv
module owd_initiator_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         ctl_wr,
  input logic         ctl_start,
  input logic [79:0]  tod,
  input logic         rx_valid,
  input logic [159:0] rx_payload,
  input logic         tx_valid,
  input logic [159:0] tx_payload,
  input logic         done,
  input logic         timeout_err
);
  logic [7:0] act;
  assign act = tx_payload[151:144];

  AST_FU_AFTER_TWO_STEP_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && act == 8'h05) |-> ($past(tx_valid) && ($past(act) == 8'h01 || $past(act) == 8'h04))); // R4

  AST_FU_CARRIES_T1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && act == 8'h05) |-> (tx_payload[143:64] == $past(tod))); // R4

  AST_ONE_STEP_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && (act == 8'h00 || act == 8'h03)) |=> !tx_valid); // R5

  AST_REQ_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && act != 8'h05) |-> ($past(ctl_wr) && $past(ctl_start))); // R2

  AST_DONE_NEEDS_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(rx_valid) && $past(rx_payload[151:144]) == 8'h02)); // R7

  AST_DONE_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout_err)); // R9
endmodule

bind owd_initiator owd_initiator_chk u_chk (.*);

// File: tb/owd_initiator_tb_top.sv
`timescale 1ns/1ps
module owd_initiator_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ctl_wr = 1'b0;
  logic [7:0]   ctl_meas_id = 8'h00;
  logic         ctl_remote = 1'b0;
  logic         ctl_two_step = 1'b0;
  logic         ctl_start = 1'b0;
  logic [15:0]  cfg_timeout = 16'd20;
  logic [47:0]  cfg_dst_mac = 48'h0A1B2C3D4E5F;
  logic         cfg_vlan_en = 1'b1;
  logic [15:0]  cfg_vlan_tag = 16'h6123;
  logic [79:0]  tod;
  logic [63:0]  cv1_in = {16'd0, 32'd400, 16'h1234};
  logic         rx_valid = 1'b0;
  logic [159:0] rx_payload = '0;
  logic         tx_valid;
  logic [159:0] tx_payload;
  logic [47:0]  tx_dst_mac;
  logic         tx_vlan_en;
  logic [15:0]  tx_vlan_tag;
  logic         done;
  logic         timeout_err;
  logic [79:0]  delay;

  always #5 clk = ~clk;

  owd_initiator dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_meas_id(ctl_meas_id),
    .ctl_remote(ctl_remote), .ctl_two_step(ctl_two_step), .ctl_start(ctl_start),
    .cfg_timeout(cfg_timeout), .cfg_dst_mac(cfg_dst_mac), .cfg_vlan_en(cfg_vlan_en),
    .cfg_vlan_tag(cfg_vlan_tag), .tod(tod), .cv1_in(cv1_in), .rx_valid(rx_valid),
    .rx_payload(rx_payload), .tx_valid(tx_valid), .tx_payload(tx_payload),
    .tx_dst_mac(tx_dst_mac), .tx_vlan_en(tx_vlan_en), .tx_vlan_tag(tx_vlan_tag),
    .done(done), .timeout_err(timeout_err), .delay(delay)
  );

  // time-of-day source: 37 ns per cycle, starting just below a second boundary
  logic [47:0] tod_s = 48'd5;
  logic [31:0] tod_n = 32'd999999700;
  assign tod = {tod_s, tod_n};
  always @(posedge clk) begin
    #2;
    if (tod_n + 32'd37 >= 32'd1000000000) begin
      tod_n = tod_n + 32'd37 - 32'd1000000000;
      tod_s = tod_s + 48'd1;
    end else begin
      tod_n = tod_n + 32'd37;
    end
  end

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  task automatic chk(string tag, logic [159:0] act, logic [159:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  function automatic logic [79:0] exp_delay(logic [79:0] t1, logic [63:0] cv1,
                                            logic [79:0] t2, logic [63:0] cv2);
    logic [127:0] a, b, d, q, r;
    a = 128'(t2[79:32]) * 128'd1000000000 + 128'(t2[31:0]) - 128'(cv2[47:16]);
    b = 128'(t1[79:32]) * 128'd1000000000 + 128'(t1[31:0]) + 128'(cv1[47:16]);
    d = a - b;
    q = d / 128'd1000000000;
    r = d % 128'd1000000000;
    return {q[47:0], r[31:0]};
  endfunction

  // behavioural reference model
  int          m_st = 0;
  int          m_cnt = 0;
  int          m_to = 0;
  logic [7:0]  m_id = '0;
  bit          m_rem = 0, m_two = 0;
  logic [47:0] m_mac = '0;
  bit          m_vlen = 0;
  logic [15:0] m_vlan = '0;
  logic [79:0] m_t1 = '0;
  bit          m_done = 0, m_err = 0;
  logic [79:0] m_delay = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_done = 0; m_err = 0; m_delay = '0;
    end else begin
      case (m_st)
        0: if (ctl_wr && ctl_start) begin
          m_id = ctl_meas_id; m_rem = ctl_remote; m_two = ctl_two_step;
          m_mac = cfg_dst_mac; m_vlen = cfg_vlan_en; m_vlan = cfg_vlan_tag;
          m_to = int'(cfg_timeout); m_done = 0; m_err = 0; m_st = 1;
        end
        1: begin
          m_t1 = tod;
          if (m_two) m_st = 2;
          else begin m_st = 3; m_cnt = m_to; end
        end
        2: begin m_st = 3; m_cnt = m_to; end
        default: begin
          if (rx_valid && rx_payload[159:152] == m_id && rx_payload[151:144] == 8'h02) begin
            m_delay = exp_delay(m_t1, cv1_in, rx_payload[143:64], rx_payload[63:0]);
            m_done = 1; m_st = 0;
          end else if (m_cnt == 0) begin
            m_err = 1; m_st = 0;
          end else begin
            m_cnt--;
          end
        end
      endcase
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [7:0]  e_act;
      logic [79:0] e_ts;
      chk("R2 tx_valid", 160'(tx_valid), 160'(m_st == 1 || m_st == 2));
      if (m_st == 1 || m_st == 2) begin
        e_act = (m_st == 2) ? 8'h05 :
                m_rem ? (m_two ? 8'h04 : 8'h03) : (m_two ? 8'h01 : 8'h00);
        e_ts  = (m_st == 2) ? m_t1 : (m_two ? 80'd0 : tod);
        chk("R2 action", 160'(tx_payload[151:144]), 160'(e_act));
        chk("R3 id", 160'(tx_payload[159:152]), 160'(m_id));
        if (m_two) begin
          chk("R4 timestamp", 160'(tx_payload[143:64]), 160'(e_ts));
          chk("R4 cv", 160'(tx_payload[63:0]), 160'(0));
        end else begin
          chk("R5 timestamp", 160'(tx_payload[143:64]), 160'(e_ts));
          chk("R5 cv", 160'(tx_payload[63:0]), 160'(0));
        end
        chk("R6 header", {95'd0, tx_dst_mac, tx_vlan_en, tx_vlan_tag},
                         {95'd0, m_mac, m_vlen, m_vlan});
      end else begin
        chk("R3 idle payload", tx_payload, 160'd0);
      end
      chk("R8 done", 160'(done), 160'(m_done));
      chk("R9 timeout_err", 160'(timeout_err), 160'(m_err));
      if (m_done) chk("R8 delay", 160'(delay), 160'(m_delay));
    end
  end

  task automatic start(logic [7:0] id, bit rem, bit two, bit st);
    @(posedge clk); #2;
    ctl_wr = 1; ctl_meas_id = id; ctl_remote = rem; ctl_two_step = two; ctl_start = st;
    @(posedge clk); #2;
    ctl_wr = 0; ctl_start = 0;
  endtask

  task automatic respond(logic [7:0] id, logic [7:0] act, logic [79:0] t2, logic [31:0] cv2_ns);
    @(posedge clk); #2;
    rx_valid = 1; rx_payload = {id, act, t2, 16'h0000, cv2_ns, 16'hBEEF};
    @(posedge clk); #2;
    rx_valid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic measure(logic [7:0] id, bit rem, bit two, logic [31:0] t2_ns, logic [31:0] cv2_ns);
    logic [79:0] t2;
    start(id, rem, two, 1);
    idle(3);
    t2 = {m_t1[79:32] + 48'd3, t2_ns};
    respond(id, 8'h02, t2, cv2_ns);
    @(negedge clk);
    chk("R7 accepted", 160'(done), 160'(1));
    chk("R8 result", 160'(delay), 160'(exp_delay(m_t1, cv1_in, t2, {16'd0, cv2_ns, 16'hBEEF})));
  endtask

  initial begin
    idle(4); #2;
    rst_n = 1;
    idle(4);
    @(negedge clk);
    chk("R1 reset tx_valid", 160'(tx_valid), 160'(0));
    chk("R1 reset done", 160'(done), 160'(0));
    chk("R1 reset timeout_err", 160'(timeout_err), 160'(0));

    // write without start bit: nothing sent
    start(8'h09, 0, 0, 0);
    @(negedge clk);
    chk("R1 no start", 160'(tx_valid), 160'(0));
    idle(3);

    // one-step request with wrong-id and wrong-action responses first
    start(8'h11, 0, 0, 1);
    idle(2);
    respond(8'h12, 8'h02, {48'd9, 32'd5}, 32'd1);
    respond(8'h11, 8'h00, {48'd9, 32'd5}, 32'd1);
    @(negedge clk);
    chk("R7 ignored", 160'(done), 160'(0));
    respond(8'h11, 8'h02, {m_t1[79:32] + 48'd3, 32'd100}, 32'd500);
    @(negedge clk);
    chk("R7 matching", 160'(done), 160'(1));
    idle(2);

    // two-step request, carry in T1 + CV1
    cv1_in = {16'd0, 32'd999999990, 16'h0};
    measure(8'h22, 0, 1, 32'd999999999, 32'd7);
    idle(2);

    // remote one-step, no VLAN, another MAC
    cfg_dst_mac = 48'hF0E1D2C3B4A5; cfg_vlan_en = 0; cfg_vlan_tag = 16'h0FFF;
    cv1_in = {16'd0, 32'd250, 16'h8};
    measure(8'h33, 1, 0, 32'd20, 32'd999999000);
    idle(2);

    // remote two-step
    cfg_vlan_en = 1; cfg_vlan_tag = 16'h2005;
    measure(8'h44, 1, 1, 32'd777, 32'd3);
    idle(2);

    // start during an active measurement is ignored
    start(8'h55, 0, 0, 1);
    idle(3);
    start(8'h66, 1, 1, 1);
    @(negedge clk);
    chk("R10 no extra frame", 160'(tx_valid), 160'(0));
    respond(8'h55, 8'h02, {m_t1[79:32] + 48'd2, 32'd4}, 32'd4);
    @(negedge clk);
    chk("R10 original id kept", 160'(done), 160'(1));
    idle(2);

    // timeout with no response, then a late response is ignored
    cfg_timeout = 16'd5;
    start(8'h77, 0, 1, 1);
    idle(12);
    @(negedge clk);
    chk("R9 expired", 160'(timeout_err), 160'(1));
    respond(8'h77, 8'h02, {48'd50, 32'd0}, 32'd0);
    @(negedge clk);
    chk("R9 late ignored", 160'(done), 160'(0));
    idle(2);

    // window edge: response at cycle timeout+1 after the frame is accepted
    cfg_timeout = 16'd4;
    start(8'h88, 0, 0, 1);
    idle(4);
    respond(8'h88, 8'h02, {m_t1[79:32] + 48'd1, 32'd0}, 32'd0);
    @(negedge clk);
    chk("R9 last cycle accepted", 160'(done), 160'(1));
    idle(2);

    // one cycle later: rejected as timed out
    start(8'h99, 0, 0, 1);
    idle(5);
    respond(8'h99, 8'h02, {m_t1[79:32] + 48'd1, 32'd0}, 32'd0);
    @(negedge clk);
    chk("R9 one past window", 160'(timeout_err), 160'(1));
    chk("R9 not done", 160'(done), 160'(0));
    idle(3);

    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end
endmodule